// File: doc/BRIEF.md
# Ten-bit parity byte packer

This block moves the error-correction parity of one 512-byte sector between two forms. The parity is eight 10-bit values, and the spare area stores it as a 10-byte code. The block has two independent halves.

The packing half takes four 32-bit result words at once. Each word holds two 10-bit values. The half joins the eight values into one continuous 80-bit little-endian bit stream and sends it out as ten bytes over a valid/ready byte stream.

The unpacking half collects ten stored code bytes over a valid/ready byte input. It then checks whether the sector is erased. If it is not, it splits the stream back into its eight 10-bit values and drives them one per cycle into a load port, last value first. A done pulse closes each unpack. An erased flag with the done pulse tells an erased sector apart, and an erased sector means no error. Computing parity and decoding syndromes happen elsewhere.

Top module: `par_pack_codec`

## Requirements
- R1: In each 32-bit result word only bits 9:0 (the lower value of the pair) and bits 25:16 (the upper value) are used; every other bit has no effect on the output bytes.
- R2: Value i (i = 0..7, value 0 being the lower field of word 0, value 1 the upper field of word 0, value 2 the lower field of word 1, and so on) occupies stream bits 10i+9..10i. Output byte k is stream bits 8k+7..8k. For example, byte 1 is bits 9:8 of value 0 in its bits 1:0 and bits 5:0 of value 1 in its bits 7:2.
- R3: Packed bytes leave in order 0 to 9. A byte is taken only on a cycle with valid and ready both high, and while ready is low the offered byte and valid stay unchanged.
- R4: A start pulse arriving while a pack is in progress is ignored; the bytes in flight still come from the words captured at the accepted start.
- R5: The unpacking input takes exactly ten bytes, then holds ready low, and bytes offered then are ignored, until the done pulse has been given.
- R6: For a sector that is not erased, load values are driven in reverse order: value 7 first, value 0 last.
- R7: A sector that is not erased gives exactly eight load strobes on consecutive cycles, and the done pulse comes in the cycle right after the eighth strobe, with the erased flag low.
- R8: If all ten collected bytes are 0xFF the sector is erased: no load strobe is driven, and done pulses with the erased flag high (meaning no error). A single cleared bit makes it a normal sector.
- R9: Unpacking the ten bytes produced by packing returns exactly the eight 10-bit fields of the original words.
- R10: After reset, no packed byte is offered, the unpack input is ready, and load strobe, done and erased are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pk_start_i | input | 1 | Begin a pack using pk_words_i |
| pk_words_i | input | 128 | Four result words, word 0 in bits 31:0 |
| pk_busy_o | output | 1 | Pack in progress |
| pk_byte_o | output | 8 | Packed code byte |
| pk_valid_o | output | 1 | pk_byte_o is valid |
| pk_ready_i | input | 1 | Sink takes the packed byte |
| up_byte_i | input | 8 | Stored code byte |
| up_valid_i | input | 1 | up_byte_i is valid |
| up_ready_o | output | 1 | Unpacker accepts a byte |
| ld_val_o | output | 10 | 10-bit value for the load port |
| ld_strobe_o | output | 1 | ld_val_o is valid this cycle |
| up_done_o | output | 1 | One-cycle end-of-unpack pulse |
| up_erased_o | output | 1 | Last sector was erased (no error) |

## Verification
The packer is driven with random words whose unused bits are also random. This separates correct field masking from leakage of the unused bits. A random stalling sink shows whether the byte order and hold behaviour survive back-pressure. A stray start pulse in the middle of a pack tests the capture rule.

The unpacker is driven with random byte streams, once with gaps in valid and once without. Reading the load sequence in reverse against the bench's own bit slicing shows whether the field borders and the order are right. The all-0xFF pattern and a near miss with a single zero bit separate a real erase check from a partial one. Round trips through both halves and a streak of extra bytes offered during emission complete the set.

// File: rtl/par_pack_pkg.sv
package par_pack_pkg;

    typedef enum logic [0:0] {
        PK_IDLE = 1'b0,
        PK_SEND = 1'b1
    } pk_state_e;

    typedef enum logic [1:0] {
        UP_COLLECT = 2'd0,
        UP_CHECK   = 2'd1,
        UP_EMIT    = 2'd2,
        UP_DONE    = 2'd3
    } up_state_e;

endpackage

// File: rtl/par_pack_tx.sv
module par_pack_tx
    import par_pack_pkg::*;
#(
    parameter int VAL_W    = 10,
    parameter int NUM_VALS = 8,
    parameter int WORD_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BYTE_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [NUM_VALS/2*WORD_W-1:0]  words_i,
    output logic                          busy_o,
    output logic [BYTE_W-1:0]             byte_o,
    output logic                          valid_o,
    input  logic                          ready_i
);
    localparam int STREAM_W  = VAL_W * NUM_VALS;
    localparam int NUM_BYTES = STREAM_W / BYTE_W;
    localparam int CNT_W     = $clog2(NUM_BYTES + 1);

    typedef struct packed {
        pk_state_e            st;
        logic [STREAM_W-1:0]  sr;
        logic [CNT_W-1:0]     cnt;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [STREAM_W-1:0] joined;
    logic unused_word_bits;

    // Gather the two fields of every word into one LSB-first stream.
    always_comb begin
        joined = '0;
        for (int i = 0; i < NUM_VALS; i++) begin
            joined[i*VAL_W +: VAL_W] = words_i[(i/2)*WORD_W + (i%2)*HALF_W +: VAL_W];
        end
    end
    assign unused_word_bits = ^words_i;

    always_comb begin
        tx_d = tx_q;
        case (tx_q.st)
            PK_IDLE: begin
                if (start_i) begin
                    tx_d.st  = PK_SEND;
                    tx_d.sr  = joined;
                    tx_d.cnt = '0;
                end
            end
            default: begin
                if (ready_i) begin
                    tx_d.sr = tx_q.sr >> BYTE_W;
                    if (tx_q.cnt == CNT_W'(NUM_BYTES - 1)) begin
                        tx_d.st  = PK_IDLE;
                        tx_d.cnt = '0;
                    end else begin
                        tx_d.cnt = tx_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{st: PK_IDLE, sr: '0, cnt: '0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign valid_o = (tx_q.st == PK_SEND);
    assign busy_o  = valid_o;
    assign byte_o  = tx_q.sr[BYTE_W-1:0];

    // Back-pressure keeps the offered byte in place.
    assert_hold_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(byte_o)));

    // Byte index stays within the code length.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.cnt < CNT_W'(NUM_BYTES));

    // A start during a stalled pack does not reload the stream.
    assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i && !ready_i) |=> $stable(tx_q.sr));
endmodule

// File: rtl/par_pack_rx.sv
module par_pack_rx
    import par_pack_pkg::*;
#(
    parameter int VAL_W    = 10,
    parameter int NUM_VALS = 8,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic [VAL_W-1:0]  load_val_o,
    output logic              load_o,
    output logic              done_o,
    output logic              erased_o
);
    localparam int STREAM_W  = VAL_W * NUM_VALS;
    localparam int NUM_BYTES = STREAM_W / BYTE_W;
    localparam int CNT_W     = $clog2(NUM_BYTES + 1);
    localparam int IDX_W     = $clog2(NUM_VALS);

    typedef struct packed {
        up_state_e            st;
        logic [STREAM_W-1:0]  sbuf;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic                 erased;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        case (rx_q.st)
            UP_COLLECT: begin
                if (valid_i) begin
                    rx_d.sbuf[int'(rx_q.cnt)*BYTE_W +: BYTE_W] = byte_i;
                    if (rx_q.cnt == CNT_W'(NUM_BYTES - 1)) begin
                        rx_d.st  = UP_CHECK;
                        rx_d.cnt = '0;
                    end else begin
                        rx_d.cnt = rx_q.cnt + 1'b1;
                    end
                end
            end
            UP_CHECK: begin
                rx_d.erased = &rx_q.sbuf;
                rx_d.st     = (&rx_q.sbuf) ? UP_DONE : UP_EMIT;
                rx_d.idx    = IDX_W'(NUM_VALS - 1);
            end
            UP_EMIT: begin
                if (rx_q.idx == '0) begin
                    rx_d.st = UP_DONE;
                end else begin
                    rx_d.idx = rx_q.idx - 1'b1;
                end
            end
            default: begin
                rx_d.st = UP_COLLECT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{st: UP_COLLECT, sbuf: '0, cnt: '0, idx: '0, erased: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign ready_o    = (rx_q.st == UP_COLLECT);
    assign load_o     = (rx_q.st == UP_EMIT);
    assign done_o     = (rx_q.st == UP_DONE);
    assign erased_o   = rx_q.erased;
    assign load_val_o = rx_q.sbuf[int'(rx_q.idx)*VAL_W +: VAL_W];

    // Strobe counter kept for the checks below.
    logic [IDX_W:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (rx_q.st == UP_CHECK) begin
            seen_q <= '0;
        end else if (load_o) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assert_eight_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !erased_o) |-> (seen_q == (IDX_W+1)'(NUM_VALS)));

    assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_o) |-> done_o);

    assert_erased_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !erased_o);

    assert_no_accept_during_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o || done_o) |-> !ready_o);
endmodule

// File: rtl/par_pack_codec.sv
module par_pack_codec #(
    parameter int VAL_W    = 10,
    parameter int NUM_VALS = 8,
    parameter int WORD_W   = 32,
    parameter int HALF_W   = 16,
    parameter int BYTE_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pk_start_i,
    input  logic [NUM_VALS/2*WORD_W-1:0]  pk_words_i,
    output logic                          pk_busy_o,
    output logic [BYTE_W-1:0]             pk_byte_o,
    output logic                          pk_valid_o,
    input  logic                          pk_ready_i,
    input  logic [BYTE_W-1:0]             up_byte_i,
    input  logic                          up_valid_i,
    output logic                          up_ready_o,
    output logic [VAL_W-1:0]              ld_val_o,
    output logic                          ld_strobe_o,
    output logic                          up_done_o,
    output logic                          up_erased_o
);
    par_pack_tx #(
        .VAL_W(VAL_W), .NUM_VALS(NUM_VALS), .WORD_W(WORD_W),
        .HALF_W(HALF_W), .BYTE_W(BYTE_W)
    ) tx_i (
        .clk(clk), .rst_n(rst_n), .start_i(pk_start_i), .words_i(pk_words_i),
        .busy_o(pk_busy_o), .byte_o(pk_byte_o), .valid_o(pk_valid_o),
        .ready_i(pk_ready_i)
    );

    par_pack_rx #(
        .VAL_W(VAL_W), .NUM_VALS(NUM_VALS), .BYTE_W(BYTE_W)
    ) rx_i (
        .clk(clk), .rst_n(rst_n), .byte_i(up_byte_i), .valid_i(up_valid_i),
        .ready_o(up_ready_o), .load_val_o(ld_val_o), .load_o(ld_strobe_o),
        .done_o(up_done_o), .erased_o(up_erased_o)
    );
endmodule

// File: tb/par_pack_codec_tb_top.sv
module par_pack_codec_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         pk_start = 1'b0;
    logic [127:0] pk_words = '0;
    logic         pk_busy, pk_valid;
    logic [7:0]   pk_byte;
    logic         pk_ready = 1'b0;
    logic [7:0]   up_byte = '0;
    logic         up_valid = 1'b0;
    logic         up_ready, ld_strobe, up_done, up_erased;
    logic [9:0]   ld_val;

    int checks = 0;
    int fails  = 0;

    par_pack_codec dut_i (
        .clk(clk), .rst_n(rst_n), .pk_start_i(pk_start), .pk_words_i(pk_words),
        .pk_busy_o(pk_busy), .pk_byte_o(pk_byte), .pk_valid_o(pk_valid),
        .pk_ready_i(pk_ready), .up_byte_i(up_byte), .up_valid_i(up_valid),
        .up_ready_o(up_ready), .ld_val_o(ld_val), .ld_strobe_o(ld_strobe),
        .up_done_o(up_done), .up_erased_o(up_erased)
    );

    task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                       input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] ref_stream(input logic [127:0] w);
        logic [79:0] s = '0;
        for (int i = 0; i < 8; i++) s[i*10 +: 10] = w[(i/2)*32 + (i%2)*16 +: 10];
        return s;
    endfunction

    function automatic logic [127:0] rand_words();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic run_pack(input logic [127:0] w, input int stall_pct,
                            input bit poke, output logic [79:0] got);
        logic [79:0] exp = ref_stream(w);
        int n = 0, guard = 0;
        bit hold = 0;
        logic [7:0] prev = '0;
        got = '0;
        @(negedge clk);
        pk_start = 1'b1; pk_words = w;
        @(negedge clk);
        pk_start = 1'b0; pk_words = rand_words();
        while (n < 10 && guard < 2000) begin
            guard++;
            if (poke) begin pk_start = 1'b1; pk_words = rand_words(); end
            pk_ready = ($urandom_range(99) >= stall_pct);
            if (hold) chk(pk_valid && pk_byte == prev, "R3 hold under stall", {72'd0, pk_byte}, {72'd0, prev});
            if (pk_valid && pk_ready) begin
                chk(pk_byte == exp[n*8 +: 8], "R1/R2 packed byte", {72'd0, pk_byte}, {72'd0, exp[n*8 +: 8]});
                got[n*8 +: 8] = pk_byte;
                n++;
            end
            hold = pk_valid && !pk_ready;
            prev = pk_byte;
            @(negedge clk);
        end
        pk_start = 1'b0; pk_ready = 1'b0;
        chk(n == 10 && !pk_valid, "R3 ten bytes then idle", 80'(n), 80'd10);
    endtask

    task automatic run_unpack(input logic [79:0] bytes, input int gap_pct,
                              output logic [79:0] vals, output int nld, output bit er);
        int sent = 0, guard = 0;
        bit prev_ld = 0;
        bit seen_done = 0;
        vals = '0; nld = 0; er = 0;
        while (sent < 10 && guard < 2000) begin
            guard++;
            up_valid = ($urandom_range(99) >= gap_pct);
            up_byte  = bytes[sent*8 +: 8];
            if (up_valid && up_ready) sent++;
            @(negedge clk);
        end
        up_valid = 1'b1; up_byte = 8'h00;   // extra byte must be ignored
        for (int c = 0; c < 40 && !seen_done; c++) begin
            if (up_done) begin
                seen_done = 1;
                er = up_erased;
                up_valid = 1'b0;
                if (!up_erased) chk(prev_ld, "R7 done right after last strobe", 80'(prev_ld), 80'd1);
            end else begin
                chk(!up_ready, "R5 ready low until done", 80'(up_ready), 80'd0);
                if (ld_strobe) begin
                    if (nld > 0) chk(prev_ld, "R7 no gap between strobes", 80'(prev_ld), 80'd1);
                    if (nld < 8) vals[nld*10 +: 10] = ld_val;
                    nld++;
                end
                prev_ld = ld_strobe;
                @(negedge clk);
            end
        end
        up_valid = 1'b0;
        chk(seen_done, "R7 done pulse seen", 80'(seen_done), 80'd1);
        @(negedge clk);
        chk(up_ready, "R5 ready returns after done", 80'(up_ready), 80'd1);
    endtask

    // Check a normal sector: eight strobes, value 7 first down to value 0.
    task automatic check_normal(input logic [79:0] bytes, input int gap_pct);
        logic [79:0] v;
        int n;
        bit e;
        run_unpack(bytes, gap_pct, v, n, e);
        chk(n == 8, "R7 eight strobes", 80'(n), 80'd8);
        chk(!e, "R7 erased flag low", 80'(e), 80'd0);
        for (int k = 0; k < 8; k++)
            chk(v[k*10 +: 10] == bytes[(7-k)*10 +: 10], "R6 reverse load order",
                80'(v[k*10 +: 10]), 80'(bytes[(7-k)*10 +: 10]));
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [79:0] b, v;
        logic [127:0] w;
        int n;
        bit e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!pk_valid && !pk_busy, "R10 no byte after reset", 80'(pk_valid), 80'd0);
        chk(up_ready, "R10 unpack ready after reset", 80'(up_ready), 80'd1);
        chk(!ld_strobe && !up_done && !up_erased, "R10 load/done/erased low",
            {77'd0, ld_strobe, up_done, up_erased}, 80'd0);

        // R2 directed: distinct field patterns across byte borders
        w = {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h003F_0300};
        run_pack(w, 0, 0, b);
        chk(b[15:8] == 8'hFF, "R2 byte1 joins value0[9:8] and value1[5:0]", 80'(b[15:8]), 80'hFF);

        // R1 garbage in unused bits, random stall
        for (int t = 0; t < 6; t++) begin
            w = rand_words();
            run_pack(w, 40, 0, b);
        end
        // R4 start pulses during the pack
        for (int t = 0; t < 3; t++) begin
            w = rand_words();
            run_pack(w, 50, 1, b);
        end

        // R6/R7 unpack random streams, with and without gaps
        for (int t = 0; t < 4; t++) begin
            b = {$urandom_range(65535), $urandom(), $urandom()};
            check_normal(b, (t % 2) ? 50 : 0);
        end

        // R8 erased sector
        run_unpack({80{1'b1}}, 30, v, n, e);
        chk(n == 0, "R8 no strobes for erased", 80'(n), 80'd0);
        chk(e, "R8 erased flag", 80'(e), 80'd1);
        // R8 near miss: one cleared bit
        b = {80{1'b1}};
        b[37] = 1'b0;
        check_normal(b, 0);

        // R9 round trip
        for (int t = 0; t < 5; t++) begin
            w = rand_words();
            run_pack(w, 20, 0, b);
            run_unpack(b, 20, v, n, e);
            for (int k = 0; k < 8; k++)
                chk(v[k*10 +: 10] == ref_stream(w)[(7-k)*10 +: 10], "R9 round trip value",
                    80'(v[k*10 +: 10]), 80'(ref_stream(w)[(7-k)*10 +: 10]));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule